// File: doc/BRIEF.md
# Raster Line and Frame Timing Generator

This block derives raster timing from the system clock. A free-running cycle divider marks the end of every scan line. A line sequencer counts lines within a frame and wraps after 263 lines in 60 Hz operation or 314 lines in 50 Hz operation. It raises a vertical-blank interrupt pulse when line 240 begins. At each wrap it emits a frame-start pulse and advances a frame counter.

The line strobe can drive a timer unit that counts in units of lines. The frame-start pulse is decoded against each timer's synchronisation setting to produce a per-timer count-clear. When interlace is fully enabled, a field bit follows the frame parity, and the same value is folded into a pass-through status bit. The duration of a line, in clock cycles, comes from an input. The region selection is sampled only at frame boundaries.

Top module: `raster_timing_gen`

## Requirements
- R1: While rst_ni is low and in the first cycle after release, line_cnt_o, frame_cnt_o and field_o are 0, vblank_o is 0, and line_stb_o, vblank_irq_o, frame_start_o and every bit of tmr_clr_o are 0.
- R2: line_stb_o is a one-cycle pulse in the last cycle of each line. A line lasts line_cycles_i clock cycles. line_cnt_o advances by one, or wraps to 0, in the cycle after the pulse and otherwise holds.
- R3: With region_i = 0 a frame lasts 263 lines, and with region_i = 1 it lasts 314 lines. The distance between successive frame_start_o pulses is therefore the line count times the line length.
- R4: In the first cycle of line 240, vblank_irq_o pulses for one cycle and vblank_o rises. vblank_o then stays high until the frame wraps.
- R5: When the last line ends, line_cnt_o returns to 0, frame_cnt_o increments by one, vblank_o falls, and frame_start_o pulses for one cycle in the first cycle of line 0.
- R6: When interlace_i is 2'b11, field_o equals bit 0 of frame_cnt_o. For any other value it is 0. stat13_o always equals stat13_i XOR field_o.
- R7: Each timer has a 3-bit setting: bit 0 enables sync and bits 2:1 hold the sync mode. tmr_clr_o for that timer pulses together with frame_start_o exactly when bit 0 is 1 and the mode is 1 or 2. It is 0 at all other times.
- R8: A change on region_i during a frame leaves that frame's length unchanged and applies from the next frame on. The first frame after reset uses the value present when reset is released.
- R9: A line_cycles_i value of 0 or 1 is treated as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| region_i | input | 1 | 0: 60 Hz / 263 lines, 1: 50 Hz / 314 lines |
| line_cycles_i | input | LINE_W | Clock cycles per line |
| interlace_i | input | 2 | Interlace configuration bits |
| stat13_i | input | 1 | Status bit to be modified by the field |
| tmr_sync_cfg_i | input | NUM_TMR x 3 | Per-timer sync enable (bit 0) and mode (bits 2:1) |
| line_stb_o | output | 1 | Last-cycle-of-line strobe |
| line_cnt_o | output | CNT_W | Current line in frame |
| vblank_o | output | 1 | Vertical blank level |
| vblank_irq_o | output | 1 | Vertical blank interrupt pulse |
| frame_start_o | output | 1 | First cycle of a frame |
| frame_cnt_o | output | FRAME_W | Frames completed since reset |
| field_o | output | 1 | Interlace field |
| stat13_o | output | 1 | stat13_i XOR field |
| tmr_clr_o | output | NUM_TMR | Per-timer count clear |

## Verification
The hardest case to reach is a region change that arrives in the middle of a frame. The frame in progress must keep its old length, and only the following frame may take the new one. Observing this takes two complete frame periods, timed from a known boundary. The bench keeps lines to a few cycles, so a frame spans only about a thousand clocks. It waits for a frame-start pulse, switches region about fifty cycles later, and then times both the current frame and the next one. The table loop also walks each setting through a boundary before it measures. This brings out the clamped line length and the different timer sync settings.

// File: rtl/rtg_pkg.sv
`timescale 1ns/1ps
package rtg_pkg;
  typedef enum logic {REGION_60HZ = 1'b0, REGION_50HZ = 1'b1} region_e;
  typedef logic [2:0] sync_cfg_t;

  // bit0 = sync enable, bits 2:1 = mode; modes 1 and 2 reset at frame start
  function automatic logic sync_clears(sync_cfg_t c);
    return c[0] && ((c[2:1] == 2'd1) || (c[2:1] == 2'd2));
  endfunction
endpackage

// File: rtl/line_divider.sv
`timescale 1ns/1ps
module line_divider #(
  parameter int LINE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_cycles_i,
  output logic              line_stb_o
);
  localparam logic [LINE_W-1:0] MIN_LEN = LINE_W'(2);

  logic [LINE_W-1:0] cyc_q;
  logic [LINE_W-1:0] eff_len;

  assign eff_len    = (line_cycles_i < MIN_LEN) ? MIN_LEN : line_cycles_i;
  // >= so a shortened length mid-line ends the line at once
  assign line_stb_o = (cyc_q >= eff_len - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cyc_q <= '0;
    else if (line_stb_o) cyc_q <= '0;
    else                 cyc_q <= cyc_q + 1'b1;
  end
endmodule

// File: rtl/frame_sequencer.sv
`timescale 1ns/1ps
module frame_sequencer
  import rtg_pkg::*;
#(
  parameter int LINES_60 = 263,
  parameter int LINES_50 = 314,
  parameter int VBL_LINE = 240,
  parameter int CNT_W    = 9,
  parameter int FRAME_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_stb_i,
  input  logic               region_i,
  output logic [CNT_W-1:0]   line_cnt_o,
  output logic               vblank_o,
  output logic               vblank_irq_o,
  output logic               frame_start_o,
  output logic [FRAME_W-1:0] frame_cnt_o
);
  localparam logic [CNT_W-1:0] LAST_60 = CNT_W'(LINES_60 - 1);
  localparam logic [CNT_W-1:0] LAST_50 = CNT_W'(LINES_50 - 1);
  localparam logic [CNT_W-1:0] PRE_VBL = CNT_W'(VBL_LINE - 1);

  logic [CNT_W-1:0]   line_q;
  logic [FRAME_W-1:0] frame_q;
  logic               vbl_q, irq_q, fs_q, started_q;
  region_e            region_q;
  logic [CNT_W-1:0]   last_line;

  assign last_line = (region_q == REGION_50HZ) ? LAST_50 : LAST_60;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q    <= '0;
      frame_q   <= '0;
      vbl_q     <= 1'b0;
      irq_q     <= 1'b0;
      fs_q      <= 1'b0;
      started_q <= 1'b0;
      region_q  <= REGION_60HZ;
    end else begin
      irq_q     <= 1'b0;
      fs_q      <= 1'b0;
      started_q <= 1'b1;
      if (!started_q) region_q <= region_e'(region_i);
      if (line_stb_i) begin
        if (line_q == last_line) begin
          line_q   <= '0;
          frame_q  <= frame_q + 1'b1;
          vbl_q    <= 1'b0;
          fs_q     <= 1'b1;
          region_q <= region_e'(region_i);
        end else begin
          line_q <= line_q + 1'b1;
          if (line_q == PRE_VBL) begin
            vbl_q <= 1'b1;
            irq_q <= 1'b1;
          end
        end
      end
    end
  end

  assign line_cnt_o    = line_q;
  assign frame_cnt_o   = frame_q;
  assign vblank_o      = vbl_q;
  assign vblank_irq_o  = irq_q;
  assign frame_start_o = fs_q;
endmodule

// File: rtl/sync_clear_decode.sv
`timescale 1ns/1ps
module sync_clear_decode
  import rtg_pkg::*;
#(
  parameter int NUM_TMR = 2
) (
  input  logic                    frame_start_i,
  input  logic [NUM_TMR-1:0][2:0] cfg_i,
  output logic [NUM_TMR-1:0]      clr_o
);
  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    assign clr_o[g] = frame_start_i & sync_clears(cfg_i[g]);
  end
endmodule

// File: rtl/raster_timing_gen.sv
`timescale 1ns/1ps
module raster_timing_gen #(
  parameter int LINE_W   = 16,
  parameter int LINES_60 = 263,
  parameter int LINES_50 = 314,
  parameter int VBL_LINE = 240,
  parameter int FRAME_W  = 16,
  parameter int NUM_TMR  = 2,
  parameter int CNT_W    = $clog2(((LINES_50 > LINES_60) ? LINES_50 : LINES_60) + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    region_i,
  input  logic [LINE_W-1:0]       line_cycles_i,
  input  logic [1:0]              interlace_i,
  input  logic                    stat13_i,
  input  logic [NUM_TMR-1:0][2:0] tmr_sync_cfg_i,
  output logic                    line_stb_o,
  output logic [CNT_W-1:0]        line_cnt_o,
  output logic                    vblank_o,
  output logic                    vblank_irq_o,
  output logic                    frame_start_o,
  output logic [FRAME_W-1:0]      frame_cnt_o,
  output logic                    field_o,
  output logic                    stat13_o,
  output logic [NUM_TMR-1:0]      tmr_clr_o
);
  logic stb;
  logic fs;

  line_divider #(.LINE_W(LINE_W)) u_div (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_cycles_i(line_cycles_i),
    .line_stb_o   (stb)
  );

  frame_sequencer #(
    .LINES_60(LINES_60), .LINES_50(LINES_50), .VBL_LINE(VBL_LINE),
    .CNT_W(CNT_W), .FRAME_W(FRAME_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_stb_i   (stb),
    .region_i     (region_i),
    .line_cnt_o   (line_cnt_o),
    .vblank_o     (vblank_o),
    .vblank_irq_o (vblank_irq_o),
    .frame_start_o(fs),
    .frame_cnt_o  (frame_cnt_o)
  );

  sync_clear_decode #(.NUM_TMR(NUM_TMR)) u_clr (
    .frame_start_i(fs),
    .cfg_i        (tmr_sync_cfg_i),
    .clr_o        (tmr_clr_o)
  );

  assign line_stb_o    = stb;
  assign frame_start_o = fs;
  assign field_o       = (interlace_i == 2'b11) & frame_cnt_o[0];
  assign stat13_o      = stat13_i ^ field_o;
endmodule

// File: rtl/rtg_checker.sv
`timescale 1ns/1ps
module rtg_checker #(
  parameter int CNT_W    = 9,
  parameter int FRAME_W  = 16,
  parameter int NUM_TMR  = 2,
  parameter int VBL_LINE = 240
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         interlace_i,
  input logic               line_stb_o,
  input logic [CNT_W-1:0]   line_cnt_o,
  input logic               vblank_o,
  input logic               vblank_irq_o,
  input logic               frame_start_o,
  input logic [FRAME_W-1:0] frame_cnt_o,
  input logic               field_o,
  input logic [NUM_TMR-1:0] tmr_clr_o
);
  p_stb_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_stb_o |=> !line_stb_o);
  p_line_adv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_stb_o |=> ((line_cnt_o == $past(line_cnt_o) + 1'b1) || (line_cnt_o == '0)));
  p_line_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_stb_o |=> $stable(line_cnt_o));
  p_vbl_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_irq_o |-> (vblank_o && (line_cnt_o == CNT_W'(VBL_LINE))));
  p_frame_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> ((line_cnt_o == '0) && !vblank_o));
  p_frame_inc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (frame_cnt_o == $past(frame_cnt_o) + 1'b1));
  p_field_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (interlace_i != 2'b11) |-> !field_o);
  p_clr_at_fs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_clr_o != '0) |-> frame_start_o);
endmodule

bind raster_timing_gen rtg_checker #(
  .CNT_W(CNT_W), .FRAME_W(FRAME_W), .NUM_TMR(NUM_TMR), .VBL_LINE(VBL_LINE)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .interlace_i  (interlace_i),
  .line_stb_o   (line_stb_o),
  .line_cnt_o   (line_cnt_o),
  .vblank_o     (vblank_o),
  .vblank_irq_o (vblank_irq_o),
  .frame_start_o(frame_start_o),
  .frame_cnt_o  (frame_cnt_o),
  .field_o      (field_o),
  .tmr_clr_o    (tmr_clr_o)
);

// File: tb/sim_raster_timing_gen.sv
`timescale 1ns/1ps
module sim_raster_timing_gen;
  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            region_i = 1'b0;
  logic [15:0]     line_cycles_i = 16'd4;
  logic [1:0]      interlace_i = 2'b00;
  logic            stat13_i = 1'b1;
  logic [1:0][2:0] tmr_sync_cfg_i = '0;
  logic            line_stb_o;
  logic [8:0]      line_cnt_o;
  logic            vblank_o, vblank_irq_o, frame_start_o;
  logic [15:0]     frame_cnt_o;
  logic            field_o, stat13_o;
  logic [1:0]      tmr_clr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk_i = ~clk_i;

  raster_timing_gen u0 (.*);

  // {region, interlace, line_cycles[7:0], cfg1, cfg0}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 2'b11, 8'd4, 3'b101, 3'b011},
    {1'b1, 2'b11, 8'd4, 3'b111, 3'b010},
    {1'b1, 2'b00, 8'd3, 3'b001, 3'b101},
    {1'b0, 2'b10, 8'd5, 3'b011, 3'b100},
    {1'b0, 2'b11, 8'd1, 3'b110, 3'b011},
    {1'b1, 2'b01, 8'd2, 3'b101, 3'b101}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic exp_clr(input logic [2:0] c);
    return c[0] && (c[2:1] == 2'd1 || c[2:1] == 2'd2);
  endfunction

  task automatic wait_fs();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk_i);
      if (frame_start_o) return;
    end
    chk(1'b0, "R5 frame_start timeout", 0, 1);
  endtask

  // Entered at a negedge where frame_start_o is high; returns at the next one.
  task automatic measure_frame(input int eff, input int lines, input logic [1:0] lace,
                               input logic [1:0][2:0] cfg, input string tag);
    int cyc = 0;
    int fprev = int'(frame_cnt_o);
    bit irq_seen = 0;
    forever begin
      @(negedge clk_i);
      cyc++;
      if (cyc > lines * eff + 20) begin
        chk(1'b0, {tag, " frame overrun"}, cyc, lines * eff);
        return;
      end
      if (tmr_clr_o != 2'b00 && !frame_start_o)
        chk(1'b0, "R7 clear outside frame start", int'(tmr_clr_o), 0);
      if (vblank_irq_o) begin
        irq_seen = 1;
        chk(cyc == 240 * eff, "R4 vblank irq cycle", cyc, 240 * eff);
        chk(line_cnt_o == 9'd240 && vblank_o, "R4 line/vblank at irq", int'(line_cnt_o), 240);
      end
      if (frame_start_o) begin
        chk(cyc == lines * eff, {tag, " frame length"}, cyc, lines * eff);
        chk(irq_seen, "R4 irq seen once per frame", int'(irq_seen), 1);
        chk(int'(frame_cnt_o) == fprev + 1, "R5 frame count step", int'(frame_cnt_o), fprev + 1);
        chk(line_cnt_o == 0 && !vblank_o, "R5 line 0, vblank low", int'(line_cnt_o), 0);
        chk(field_o == ((lace == 2'b11) ? frame_cnt_o[0] : 1'b0), "R6 field",
            int'(field_o), int'((lace == 2'b11) ? frame_cnt_o[0] : 1'b0));
        chk(stat13_o == (stat13_i ^ field_o), "R6 status bit", int'(stat13_o),
            int'(stat13_i ^ field_o));
        chk(tmr_clr_o == {exp_clr(cfg[1]), exp_clr(cfg[0])}, "R7 timer clear",
            int'(tmr_clr_o), int'({exp_clr(cfg[1]), exp_clr(cfg[0])}));
        return;
      end
    end
  endtask

  task automatic check_reset_state(input string tag);
    chk(line_cnt_o == 0 && frame_cnt_o == 0 && field_o == 0, {tag, " R1 counters"},
        int'(line_cnt_o) + int'(frame_cnt_o) + int'(field_o), 0);
    chk(!vblank_o && !line_stb_o && !vblank_irq_o && !frame_start_o && tmr_clr_o == 0,
        {tag, " R1 strobes"}, int'({vblank_o, line_stb_o, vblank_irq_o, frame_start_o, tmr_clr_o}), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int eff;
    int ln;
    int l0;
    repeat (3) @(negedge clk_i);
    check_reset_state("in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_reset_state("after release");

    // Table walk: apply a setting, let it reach a frame boundary, then time a frame.
    foreach (VEC[k]) begin
      region_i       = VEC[k][16];
      interlace_i    = VEC[k][15:14];
      line_cycles_i  = {8'd0, VEC[k][13:6]};
      tmr_sync_cfg_i = {VEC[k][5:3], VEC[k][2:0]};
      eff = (VEC[k][13:6] < 2) ? 2 : int'(VEC[k][13:6]);  // R9
      ln  = VEC[k][16] ? 314 : 263;
      wait_fs();
      measure_frame(eff, ln, interlace_i, tmr_sync_cfg_i,
                    (VEC[k][13:6] < 2) ? "R9 R3" : "R3");
      measure_frame(eff, ln, interlace_i, tmr_sync_cfg_i, "R3");
    end

    // R2: strobe shape and line advance, 3-cycle lines
    line_cycles_i = 16'd3;
    wait_fs();
    for (int n = 0; n < 3; n++) begin
      int gap = 0;
      while (!line_stb_o) @(negedge clk_i);
      l0 = int'(line_cnt_o);
      @(negedge clk_i);
      gap = 1;
      chk(!line_stb_o, "R2 strobe one cycle", int'(line_stb_o), 0);
      chk(int'(line_cnt_o) == l0 + 1, "R2 line advance", int'(line_cnt_o), l0 + 1);
      while (!line_stb_o) begin
        @(negedge clk_i);
        gap++;
      end
      chk(gap == 3, "R2 strobe period", gap, 3);
    end

    // R8: region switch mid-frame
    region_i = 1'b0;
    line_cycles_i = 16'd4;
    tmr_sync_cfg_i = '0;
    wait_fs();
    wait_fs();
    repeat (50) @(negedge clk_i);
    region_i = 1'b1;
    l0 = 50;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk_i);
      l0++;
      if (frame_start_o) break;
    end
    chk(l0 == 263 * 4, "R8 current frame keeps length", l0, 263 * 4);
    measure_frame(4, 314, interlace_i, tmr_sync_cfg_i, "R8 next frame");

    // R1: reset mid-run
    repeat (37) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check_reset_state("mid-run reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_reset_state("mid-run release");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule